// File: doc/BRIEF.md
# Cross-Stream Duplicate Track Cancellation and Best-Three Selector

This block takes six track candidates that two separate assembly streams built in the same bunch crossing, three from each stream. Each candidate names the segment it uses in each of four stations, or none, and carries a 4-bit quality. Two streams can assemble the same muon from shared segments. To stop that muon from appearing twice, every track of the first stream is compared with every track of the second stream. When two tracks overlap, one of them is cancelled.

The rule that picks which track is cancelled works in three steps. The track that spans fewer stations loses. If both span the same number of stations, the one with the lower quality loses. If the qualities are also equal, the second-stream track loses. All nine verdicts are taken from the raw inputs at the same moment, so they never depend on each other. The surviving tracks are then ranked by quality, and the best three are presented on registered output slots. Each slot carries the index of its source candidate, the quality and the segment identifiers. A new set of six candidates can be accepted on every clock.

Top module: `dtc_cancel_sel`

## Requirements
- R1: While reset is asserted, and for the first two clocks after it is released, every output slot has its valid bit low.
- R2: A candidate set sampled on clock edge k appears on the outputs after edge k+2. The block is fully pipelined and accepts a new set every cycle.
- R3: Two tracks overlap only when they hold the same nonzero segment identifier in the same station. An identifier of 0 means the station is empty, and an identical identifier in different stations is not an overlap.
- R4: When overlapping tracks span different numbers of stations, the track with fewer occupied stations is cancelled.
- R5: When overlapping tracks span the same number of stations, the track with the lower quality is cancelled. When the qualities are also equal, the second-stream track (index 3 to 5) is cancelled.
- R6: Only cross-stream pairs are compared. Two tracks from the same stream never cancel each other, even if they are identical.
- R7: Every verdict is taken from the inputs as presented. A track that is itself cancelled still cancels the tracks it beats.
- R8: Surviving tracks fill the slots in descending order of quality, with slot 0 holding the best. Equal qualities are ordered by the lower input index first.
- R9: When fewer than three tracks survive, the filled slots are the lowest-numbered ones, and the remaining slots have valid low.
- R10: Each valid slot carries the source index of its candidate (0 to 2 for the first stream, 3 to 5 for the second), together with that candidate's quality and its four segment identifiers, unchanged.
- R11: A candidate whose valid bit is low is neither selected nor able to cancel any other candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cand_vld | input | 6 | Valid bit for each candidate. Bits 0 to 2 belong to stream one, bits 3 to 5 to stream two |
| cand_seg | input | 96 | Segment identifiers. Candidate t, station s is at bits [(t*4+s)*4 +: 4]. The value 0 means the station is empty |
| cand_qual | input | 24 | Quality of candidate t, at bits [t*4 +: 4] |
| sel_vld | output | 3 | Valid bit for each output slot |
| sel_idx | output | 9 | Source index for slot k, at bits [k*3 +: 3] |
| sel_qual | output | 12 | Quality for slot k, at bits [k*4 +: 4] |
| sel_seg | output | 48 | Segment identifiers for slot k, at bits [k*16 +: 16], with the station order unchanged |

## Verification
The bench builds the block with its default parameters: three tracks per stream, four stations, and 4-bit segment and quality fields. In the random vectors the segment identifiers are limited to the values 0 to 3 and the qualities are drawn from narrow ranges. This keeps empty stations, cross-stream overlaps, length ties and quality ties frequent. The bench streams a new set every cycle, so both the two-cycle latency and the back-to-back throughput are checked on every vector. Directed sets cover the cases that random draws rarely produce: chained cancellation, identical tracks within one stream, and invalid candidates that overlap with valid ones.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  // Outcome of one cross-stream comparison
  typedef enum logic [1:0] {
    VERDICT_KEEP   = 2'd0,
    VERDICT_DROP_A = 2'd1,
    VERDICT_DROP_B = 2'd2
  } verdict_e;

  // Loser choice for an overlapping pair: shorter loses, then lower
  // quality, and on a full tie the second-stream track goes.
  function automatic verdict_e settle(input int unsigned len_a,
                                      input int unsigned len_b,
                                      input int unsigned q_a,
                                      input int unsigned q_b);
    if (len_a > len_b) return VERDICT_DROP_B;
    if (len_b > len_a) return VERDICT_DROP_A;
    if (q_a > q_b)     return VERDICT_DROP_B;
    if (q_b > q_a)     return VERDICT_DROP_A;
    return VERDICT_DROP_B;
  endfunction

endpackage

// File: rtl/dtc_pair_cmp.sv
module dtc_pair_cmp
  import dtc_pkg::*;
#(
  parameter int N_STA  = 4,
  parameter int SEG_W  = 4,
  parameter int QUAL_W = 4
) (
  input  logic                   vld_a,
  input  logic                   vld_b,
  input  logic [N_STA*SEG_W-1:0] seg_a,
  input  logic [N_STA*SEG_W-1:0] seg_b,
  input  logic [QUAL_W-1:0]      qual_a,
  input  logic [QUAL_W-1:0]      qual_b,
  output logic                   overlap,
  output logic                   drop_a,
  output logic                   drop_b
);

  localparam int TRK_W = N_STA * SEG_W;

  logic [N_STA-1:0] sta_hit;
  verdict_e         verdict;

  function automatic int unsigned occupied(input logic [TRK_W-1:0] trk);
    int unsigned n = 0;
    for (int s = 0; s < N_STA; s++)
      if (trk[s*SEG_W +: SEG_W] != '0) n++;
    return n;
  endfunction

  for (genvar s = 0; s < N_STA; s++) begin : g_sta
    assign sta_hit[s] = (seg_a[s*SEG_W +: SEG_W] != '0) &&
                        (seg_a[s*SEG_W +: SEG_W] == seg_b[s*SEG_W +: SEG_W]);
  end

  always_comb begin
    overlap = vld_a && vld_b && (|sta_hit);
    verdict = settle(occupied(seg_a), occupied(seg_b),
                     int'(qual_a), int'(qual_b));
    drop_a  = overlap && (verdict == VERDICT_DROP_A);
    drop_b  = overlap && (verdict == VERDICT_DROP_B);
  end

endmodule

// File: rtl/dtc_rank_sel.sv
module dtc_rank_sel #(
  parameter int N_TRK  = 6,
  parameter int N_SEL  = 3,
  parameter int N_STA  = 4,
  parameter int SEG_W  = 4,
  parameter int QUAL_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_TRK-1:0]             surv,
  input  logic [N_TRK*N_STA*SEG_W-1:0] trk_seg,
  input  logic [N_TRK*QUAL_W-1:0]      trk_qual,
  output logic [N_SEL-1:0]             sel_vld,
  output logic [N_SEL*$clog2(N_TRK)-1:0] sel_idx,
  output logic [N_SEL*QUAL_W-1:0]      sel_qual,
  output logic [N_SEL*N_STA*SEG_W-1:0] sel_seg
);

  localparam int TRK_W = N_STA * SEG_W;
  localparam int IDX_W = $clog2(N_TRK);
  localparam int CNT_W = $clog2(N_TRK + 1);

  logic [N_TRK-1:0][CNT_W-1:0] rank;
  logic [N_SEL-1:0]            nxt_vld;
  logic [N_SEL*IDX_W-1:0]      nxt_idx;
  logic [N_SEL*QUAL_W-1:0]     nxt_qual;
  logic [N_SEL*TRK_W-1:0]      nxt_seg;

  // Track j is placed ahead of track i
  function automatic logic outranks(input logic [QUAL_W-1:0] q_j, input int j,
                                    input logic [QUAL_W-1:0] q_i, input int i);
    return (q_j > q_i) || ((q_j == q_i) && (j < i));
  endfunction

  // Rank of each track = number of survivors placed ahead of it
  always_comb begin
    for (int i = 0; i < N_TRK; i++) begin
      rank[i] = '0;
      for (int j = 0; j < N_TRK; j++)
        if (j != i && surv[j] &&
            outranks(trk_qual[j*QUAL_W +: QUAL_W], j, trk_qual[i*QUAL_W +: QUAL_W], i))
          rank[i] = rank[i] + CNT_W'(1);
    end
  end

  // Slot k takes the survivor whose rank equals k
  for (genvar k = 0; k < N_SEL; k++) begin : g_slot
    always_comb begin
      nxt_vld[k]                        = 1'b0;
      nxt_idx[k*IDX_W +: IDX_W]         = '0;
      nxt_qual[k*QUAL_W +: QUAL_W]      = '0;
      nxt_seg[k*TRK_W +: TRK_W]         = '0;
      for (int i = 0; i < N_TRK; i++)
        if (surv[i] && rank[i] == CNT_W'(k)) begin
          nxt_vld[k]                    = 1'b1;
          nxt_idx[k*IDX_W +: IDX_W]     = IDX_W'(i);
          nxt_qual[k*QUAL_W +: QUAL_W]  = trk_qual[i*QUAL_W +: QUAL_W];
          nxt_seg[k*TRK_W +: TRK_W]     = trk_seg[i*TRK_W +: TRK_W];
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_vld  <= '0;
      sel_idx  <= '0;
      sel_qual <= '0;
      sel_seg  <= '0;
    end else begin
      sel_vld  <= nxt_vld;
      sel_idx  <= nxt_idx;
      sel_qual <= nxt_qual;
      sel_seg  <= nxt_seg;
    end
  end

endmodule

// File: rtl/dtc_cancel_sel.sv
module dtc_cancel_sel #(
  parameter int N_PER  = 3,
  parameter int N_STA  = 4,
  parameter int SEG_W  = 4,
  parameter int QUAL_W = 4,
  parameter int N_SEL  = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [2*N_PER-1:0]               cand_vld,
  input  logic [2*N_PER*N_STA*SEG_W-1:0]   cand_seg,
  input  logic [2*N_PER*QUAL_W-1:0]        cand_qual,
  output logic [N_SEL-1:0]                 sel_vld,
  output logic [N_SEL*$clog2(2*N_PER)-1:0] sel_idx,
  output logic [N_SEL*QUAL_W-1:0]          sel_qual,
  output logic [N_SEL*N_STA*SEG_W-1:0]     sel_seg
);

  localparam int N_TRK  = 2 * N_PER;
  localparam int TRK_W  = N_STA * SEG_W;
  localparam int N_PAIR = N_PER * N_PER;

  // Named internal events for the checker
  logic [N_PAIR-1:0] pair_ovl;
  logic [N_PAIR-1:0] pair_drop_a;
  logic [N_PAIR-1:0] pair_drop_b;
  logic [N_TRK-1:0]  kill;
  logic [N_TRK-1:0]  survive;

  logic [N_TRK-1:0]       s1_surv;
  logic [N_TRK*TRK_W-1:0] s1_seg;
  logic [N_TRK*QUAL_W-1:0] s1_qual;

  // One comparator per cross-stream pairing: first-stream a, second-stream b
  for (genvar a = 0; a < N_PER; a++) begin : g_a
    for (genvar b = 0; b < N_PER; b++) begin : g_b
      dtc_pair_cmp #(
        .N_STA (N_STA),
        .SEG_W (SEG_W),
        .QUAL_W(QUAL_W)
      ) u_cmp (
        .vld_a  (cand_vld[a]),
        .vld_b  (cand_vld[N_PER+b]),
        .seg_a  (cand_seg[a*TRK_W +: TRK_W]),
        .seg_b  (cand_seg[(N_PER+b)*TRK_W +: TRK_W]),
        .qual_a (cand_qual[a*QUAL_W +: QUAL_W]),
        .qual_b (cand_qual[(N_PER+b)*QUAL_W +: QUAL_W]),
        .overlap(pair_ovl[a*N_PER+b]),
        .drop_a (pair_drop_a[a*N_PER+b]),
        .drop_b (pair_drop_b[a*N_PER+b])
      );
    end
  end

  // Gather the verdicts per track; all verdicts count at once
  always_comb begin
    kill = '0;
    for (int a = 0; a < N_PER; a++)
      for (int b = 0; b < N_PER; b++) begin
        kill[a]       = kill[a]       | pair_drop_a[a*N_PER+b];
        kill[N_PER+b] = kill[N_PER+b] | pair_drop_b[a*N_PER+b];
      end
  end

  assign survive = cand_vld & ~kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_surv <= '0;
      s1_seg  <= '0;
      s1_qual <= '0;
    end else begin
      s1_surv <= survive;
      s1_seg  <= cand_seg;
      s1_qual <= cand_qual;
    end
  end

  dtc_rank_sel #(
    .N_TRK (N_TRK),
    .N_SEL (N_SEL),
    .N_STA (N_STA),
    .SEG_W (SEG_W),
    .QUAL_W(QUAL_W)
  ) u_rank (
    .clk     (clk),
    .rst_n   (rst_n),
    .surv    (s1_surv),
    .trk_seg (s1_seg),
    .trk_qual(s1_qual),
    .sel_vld (sel_vld),
    .sel_idx (sel_idx),
    .sel_qual(sel_qual),
    .sel_seg (sel_seg)
  );

endmodule

// File: rtl/dtc_cancel_sel_chk.sv
module dtc_cancel_sel_chk #(
  parameter int N_PER  = 3,
  parameter int N_SEL  = 3,
  parameter int QUAL_W = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [2*N_PER-1:0]               cand_vld,
  input logic [N_PER*N_PER-1:0]           pair_ovl,
  input logic [N_PER*N_PER-1:0]           pair_drop_a,
  input logic [N_PER*N_PER-1:0]           pair_drop_b,
  input logic [2*N_PER-1:0]               kill,
  input logic [N_SEL-1:0]                 sel_vld,
  input logic [N_SEL*$clog2(2*N_PER)-1:0] sel_idx,
  input logic [N_SEL*QUAL_W-1:0]          sel_qual
);

  localparam int N_TRK = 2 * N_PER;
  localparam int IDX_W = $clog2(N_TRK);

  // Cycles since reset release, saturating at 2
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2) since_rst <= since_rst + 2'd1;
  end

  // R1: slots stay empty until the pipeline has refilled
  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2) |-> (sel_vld == '0));

  // R2: no more slots filled than candidates offered two edges earlier
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2) |-> ($countones(sel_vld) <= $countones($past(cand_vld, 2))));

  // R3: a drop only ever follows a detected overlap
  a_r3_drop_needs_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    ((pair_drop_a | pair_drop_b) & ~pair_ovl) == '0);

  // R11: an invalid candidate is never the target of a cancellation
  a_r11_no_kill_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (kill & ~cand_vld) == '0);

  for (genvar p = 0; p < N_PER*N_PER; p++) begin : g_pair
    // R5: an overlapping pair loses exactly one member
    a_r5_one_loser: assert property (@(posedge clk) disable iff (!rst_n)
      pair_ovl[p] |-> $onehot({pair_drop_a[p], pair_drop_b[p]}));
  end

  for (genvar k = 0; k < N_SEL; k++) begin : g_slot
    // R10: the source index names a real candidate
    a_r10_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      sel_vld[k] |-> (int'(sel_idx[k*IDX_W +: IDX_W]) < N_TRK));
    if (k > 0) begin : g_ord
      // R9: filled slots are packed from slot 0
      a_r9_packed: assert property (@(posedge clk) disable iff (!rst_n)
        sel_vld[k] |-> sel_vld[k-1]);
      // R8: quality never rises from one slot to the next
      a_r8_descending: assert property (@(posedge clk) disable iff (!rst_n)
        sel_vld[k] |-> (sel_qual[(k-1)*QUAL_W +: QUAL_W] >= sel_qual[k*QUAL_W +: QUAL_W]));
      // R8: equal qualities keep ascending index order
      a_r8_tie_order: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_vld[k] && sel_qual[(k-1)*QUAL_W +: QUAL_W] == sel_qual[k*QUAL_W +: QUAL_W])
        |-> (sel_idx[(k-1)*IDX_W +: IDX_W] < sel_idx[k*IDX_W +: IDX_W]));
    end
  end

endmodule

bind dtc_cancel_sel dtc_cancel_sel_chk #(
  .N_PER (N_PER),
  .N_SEL (N_SEL),
  .QUAL_W(QUAL_W)
) u_dtc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cand_vld   (cand_vld),
  .pair_ovl   (pair_ovl),
  .pair_drop_a(pair_drop_a),
  .pair_drop_b(pair_drop_b),
  .kill       (kill),
  .sel_vld    (sel_vld),
  .sel_idx    (sel_idx),
  .sel_qual   (sel_qual)
);

// File: tb/test_dtc_cancel_sel.sv
`timescale 1ns/1ps
module test_dtc_cancel_sel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cand_vld = '0;
  logic [95:0] cand_seg = '0;
  logic [23:0] cand_qual = '0;
  logic [2:0]  sel_vld;
  logic [8:0]  sel_idx;
  logic [11:0] sel_qual;
  logic [47:0] sel_seg;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dtc_cancel_sel i_dtc_cancel_sel (
    .clk(clk), .rst_n(rst_n), .cand_vld(cand_vld), .cand_seg(cand_seg),
    .cand_qual(cand_qual), .sel_vld(sel_vld), .sel_idx(sel_idx),
    .sel_qual(sel_qual), .sel_seg(sel_seg)
  );

  // Expected results for the last two sets driven (h1 newer, h2 older)
  logic [2:0]  h1_v = '0, h2_v = '0;
  logic [8:0]  h1_i = '0, h2_i = '0;
  logic [11:0] h1_q = '0, h2_q = '0;
  logic [47:0] h1_s = '0, h2_s = '0;
  string       h1_t = "R1", h2_t = "R1";

  logic [5:0]  dv;
  logic [95:0] ds;
  logic [23:0] dq;

  function automatic logic [15:0] trk(input logic [3:0] s0, s1, s2, s3);
    return {s3, s2, s1, s0};
  endfunction

  function automatic int stations(input logic [15:0] t);
    int n = 0;
    for (int s = 0; s < 4; s++) if (t[s*4 +: 4] != 4'd0) n++;
    return n;
  endfunction

  function automatic bit shares(input logic [15:0] x, input logic [15:0] y);
    for (int s = 0; s < 4; s++)
      if (x[s*4 +: 4] != 4'd0 && x[s*4 +: 4] == y[s*4 +: 4]) return 1;
    return 0;
  endfunction

  // Reference: cancel from the raw inputs, then pick the best three by repeated search
  task automatic model(input logic [5:0] v, input logic [95:0] s, input logic [23:0] q,
                       output logic [2:0] ov, output logic [8:0] oi,
                       output logic [11:0] oq, output logic [47:0] os);
    bit dead[6];
    bit taken[6];
    for (int t = 0; t < 6; t++) begin dead[t] = 0; taken[t] = 0; end
    for (int a = 0; a < 3; a++)
      for (int b = 3; b < 6; b++)
        if (v[a] && v[b] && shares(s[a*16 +: 16], s[b*16 +: 16])) begin
          int la = stations(s[a*16 +: 16]);
          int lb = stations(s[b*16 +: 16]);
          int qa = int'(q[a*4 +: 4]);
          int qb = int'(q[b*4 +: 4]);
          if (la != lb)      begin if (la < lb) dead[a] = 1; else dead[b] = 1; end
          else if (qa != qb) begin if (qa < qb) dead[a] = 1; else dead[b] = 1; end
          else               dead[b] = 1;
        end
    ov = '0; oi = '0; oq = '0; os = '0;
    for (int k = 0; k < 3; k++) begin
      int best = -1;
      for (int t = 0; t < 6; t++)
        if (v[t] && !dead[t] && !taken[t] &&
            (best < 0 || q[t*4 +: 4] > q[best*4 +: 4])) best = t;
      if (best >= 0) begin
        taken[best]   = 1;
        ov[k]         = 1'b1;
        oi[k*3 +: 3]  = 3'(best);
        oq[k*4 +: 4]  = q[best*4 +: 4];
        os[k*16 +: 16] = s[best*16 +: 16];
      end
    end
  endtask

  task automatic compare_out();
    checks++;
    if (sel_vld !== h2_v) begin
      failures++;
      $display("FAIL %s sel_vld actual=%b expected=%b", h2_t, sel_vld, h2_v);
    end
    for (int k = 0; k < 3; k++)
      if (h2_v[k]) begin
        checks++;
        if (sel_idx[k*3 +: 3] !== h2_i[k*3 +: 3] || sel_qual[k*4 +: 4] !== h2_q[k*4 +: 4] ||
            sel_seg[k*16 +: 16] !== h2_s[k*16 +: 16]) begin
          failures++;
          $display("FAIL %s slot%0d actual idx=%0d q=%0d seg=%h expected idx=%0d q=%0d seg=%h",
                   h2_t, k, sel_idx[k*3 +: 3], sel_qual[k*4 +: 4], sel_seg[k*16 +: 16],
                   h2_i[k*3 +: 3], h2_q[k*4 +: 4], h2_s[k*16 +: 16]);
        end
      end
  endtask

  // Check the set from two negedges ago, then drive the next one
  task automatic apply(input logic [5:0] v, input logic [95:0] s, input logic [23:0] q,
                       input string tag);
    @(negedge clk);
    compare_out();
    h2_v = h1_v; h2_i = h1_i; h2_q = h1_q; h2_s = h1_s; h2_t = h1_t;
    cand_vld = v; cand_seg = s; cand_qual = q;
    model(v, s, q, h1_v, h1_i, h1_q, h1_s);
    h1_t = tag;
  endtask

  task automatic idle(input string tag);
    apply('0, '0, '0, tag);
  endtask

  initial begin
    void'($urandom(32'd1999));
    // R1: outputs empty while reset is held
    repeat (3) @(negedge clk);
    checks++;
    if (sel_vld !== 3'b000) begin
      failures++;
      $display("FAIL R1 sel_vld in reset actual=%b expected=000", sel_vld);
    end
    rst_n = 1'b1;

    // R2: single set followed by idles; appears exactly two edges later
    ds = '0; dq = '0;
    ds[0*16 +: 16] = trk(1, 2, 3, 0); dq[0*4 +: 4] = 4'd9;
    apply(6'b000001, ds, dq, "R2");
    idle("R2"); idle("R2"); idle("R2");

    // R3: zero ids never match; same id in different stations is no overlap
    ds = '0; dq = '0;
    ds[0*16 +: 16] = trk(0, 2, 3, 0); dq[0*4 +: 4] = 4'd5;
    ds[1*16 +: 16] = trk(7, 0, 0, 0); dq[1*4 +: 4] = 4'd4;
    ds[3*16 +: 16] = trk(0, 5, 6, 0); dq[3*4 +: 4] = 4'd6;
    ds[4*16 +: 16] = trk(0, 7, 0, 0); dq[4*4 +: 4] = 4'd3;
    apply(6'b011011, ds, dq, "R3");

    // R4: longer second-stream track cancels shorter first-stream one
    ds = '0; dq = '0;
    ds[0*16 +: 16] = trk(1, 2, 0, 0); dq[0*4 +: 4] = 4'd15;
    ds[3*16 +: 16] = trk(1, 3, 4, 0); dq[3*4 +: 4] = 4'd2;
    apply(6'b001001, ds, dq, "R4");
    // R4: and the reverse direction
    ds = '0; dq = '0;
    ds[2*16 +: 16] = trk(1, 2, 3, 4); dq[2*4 +: 4] = 4'd1;
    ds[5*16 +: 16] = trk(0, 0, 3, 5); dq[5*4 +: 4] = 4'd14;
    apply(6'b100100, ds, dq, "R4");

    // R5: equal length, lower quality loses
    ds = '0; dq = '0;
    ds[1*16 +: 16] = trk(2, 2, 2, 0); dq[1*4 +: 4] = 4'd3;
    ds[4*16 +: 16] = trk(2, 1, 1, 0); dq[4*4 +: 4] = 4'd8;
    apply(6'b010010, ds, dq, "R5");
    // R5: full tie, second stream loses
    ds = '0; dq = '0;
    ds[0*16 +: 16] = trk(3, 3, 0, 0); dq[0*4 +: 4] = 4'd7;
    ds[5*16 +: 16] = trk(3, 3, 0, 0); dq[5*4 +: 4] = 4'd7;
    apply(6'b100001, ds, dq, "R5");

    // R6: identical tracks inside one stream both survive
    ds = '0; dq = '0;
    ds[0*16 +: 16] = trk(1, 1, 1, 1); dq[0*4 +: 4] = 4'd6;
    ds[1*16 +: 16] = trk(1, 1, 1, 1); dq[1*4 +: 4] = 4'd6;
    ds[4*16 +: 16] = trk(1, 1, 1, 1); dq[4*4 +: 4] = 4'd6;
    ds[5*16 +: 16] = trk(2, 2, 2, 2); dq[5*4 +: 4] = 4'd6;
    apply(6'b110011, ds, dq, "R6");

    // R7: a cancelled track still cancels: A0(4) kills B0(3), B0 kills A1(2)
    ds = '0; dq = '0;
    ds[0*16 +: 16] = trk(1, 2, 3, 4); dq[0*4 +: 4] = 4'd2;
    ds[3*16 +: 16] = trk(1, 5, 6, 0); dq[3*4 +: 4] = 4'd9;
    ds[1*16 +: 16] = trk(0, 5, 0, 7); dq[1*4 +: 4] = 4'd12;
    ds[2*16 +: 16] = trk(0, 0, 8, 8); dq[2*4 +: 4] = 4'd1;
    apply(6'b001111, ds, dq, "R7");

    // R8: ties ordered by index, more survivors than slots
    ds = '0; dq = '0;
    for (int t = 0; t < 6; t++) begin
      ds[t*16 +: 16] = trk(4'(t + 1), 0, 0, 4'(t + 9)); dq[t*4 +: 4] = 4'd5;
    end
    dq[4*4 +: 4] = 4'd10;
    apply(6'b111111, ds, dq, "R8");

    // R9: one survivor only
    ds = '0; dq = '0;
    ds[4*16 +: 16] = trk(9, 9, 0, 0); dq[4*4 +: 4] = 4'd0;
    apply(6'b010000, ds, dq, "R9");
    // R9: two survivors
    ds[1*16 +: 16] = trk(1, 0, 0, 0); dq[1*4 +: 4] = 4'd0;
    apply(6'b010010, ds, dq, "R9");

    // R11: invalid overlapping long track neither cancels nor appears
    ds = '0; dq = '0;
    ds[0*16 +: 16] = trk(1, 2, 3, 4); dq[0*4 +: 4] = 4'd15;
    ds[3*16 +: 16] = trk(1, 0, 0, 0); dq[3*4 +: 4] = 4'd1;
    apply(6'b001000, ds, dq, "R11");
    idle("R11");

    // R10 and all rules together: random sets, back to back
    for (int n = 0; n < 600; n++) begin
      dv = 6'($urandom);
      for (int t = 0; t < 6; t++) begin
        for (int s = 0; s < 4; s++) ds[(t*4+s)*4 +: 4] = 4'($urandom % 4);
        dq[t*4 +: 4] = (n % 2 == 0) ? 4'($urandom % 3) : 4'($urandom);
      end
      apply(dv, ds, dq, "R10");
    end
    idle("R10"); idle("R10"); idle("R10");

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule